// File: doc/BRIEF.md
# Instruction-Strobed Watchdog Timer

This block is a watchdog for a small processor core. The core's decoder reports two instructions to it by single-cycle strobes: one that switches the watchdog on and then refreshes it, and one that lets it keep counting while the core is halted. The core also reports whether it sits in its halt or stop low-power state. A strapped option input selects a permanent watchdog that needs no instruction at all.

While the watchdog is running, a counter advances once per clock. If the counter reaches the timeout without a refresh, the block raises a reset request. That request is held for a fixed stretch equal to the power-on delay plus eighteen extra oscillator cycles, so the rest of the chip sees the same reset it gets at power-up. Once the software enables the watchdog, no instruction can switch it off. The refresh instruction also changes the zero, sign and overflow flags, so the block supplies their values and a load strobe for the core's flag register.

Top module: `insn_watchdog`

## Requirements
- R1: While `rstN` is low and just after it rises, `wdReset` is 0. With `permOpt` at 0, `wdRunning` is also 0 until the first refresh strobe.
- R2: The first `refreshStb` pulse outside a reset stretch enables the watchdog. `wdRunning` reads 1 after that clock edge, unless halt or stop blocks counting.
- R3: `wdReset` rises at the clock edge that ends the TIMEOUT_CLKS-th running cycle counted from enable or from the last refresh. A refresh strobe clears the count and also prevents the reset when it falls in that last cycle.
- R4: `wdReset` stays high for exactly POR_CLKS+OSC_EXTRA cycles and then falls. While it is high, `wdRunning` is 0 and both strobes are ignored.
- R5: No strobe or input disables an enabled watchdog. Halt or stop only pause the count, and the count keeps its value across the pause.
- R6: A software-enabled watchdog without the halt-run latch does not count while `inHalt` is 1.
- R7: A `haltRunStb` pulse while the watchdog is enabled sets a latch that keeps it counting during halt. The pulse does not clear the count.
- R8: A `haltRunStb` pulse while the watchdog is not enabled has no effect. A later enable still pauses during halt.
- R9: A software-enabled watchdog never counts while `inStop` is 1, even with the halt-run latch set.
- R10: With `permOpt` at 1, the watchdog counts from the first edge after reset without any strobe, and it counts through both halt and stop.
- R11: A watchdog timeout clears the enable and halt-run latches when `permOpt` is 0. With `permOpt` at 1, counting resumes once the stretch ends.
- R12: In the cycle that `refreshStb` is high, `flagLoad` is 1 and `flagZsv` is 3'b100, with bit 2 = Z = 1, bit 1 = S = 0 and bit 0 = V = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| refreshStb | input | 1 | One-cycle strobe: enable/refresh instruction executed |
| haltRunStb | input | 1 | One-cycle strobe: keep-running-in-halt instruction executed |
| inHalt | input | 1 | Core is in its halt state |
| inStop | input | 1 | Core is in its stop state |
| permOpt | input | 1 | Permanent-watchdog option, static after reset |
| wdReset | output | 1 | Stretched reset request after a timeout |
| wdRunning | output | 1 | Counter advances at the coming edge |
| flagLoad | output | 1 | Load strobe for the core's Z, S and V flags |
| flagZsv | output | 3 | Flag values to load: {Z, S, V} |

## Verification
The assertions assume that `permOpt` changes only while `rstN` is low, and that inputs change between clock edges. The bench sets the option inside its reset task and drives every input just after the falling edge. The properties on permanent running, stop pausing and latch persistence rely on those conditions. Each scenario starts from a fresh reset, so latch state from one scenario never leaks into the checks of the next.

// File: rtl/insn_wdog_pkg.sv
package insn_wdog_pkg;
  // Strobes from control to the counting datapath
  typedef struct packed {
    logic clr;    // restart the timeout count
    logic run;    // advance the timeout count
    logic fire;   // timeout reached: start the reset stretch
  } cntCtl_t;

  // {Z, S, V} left behind by the refresh instruction
  localparam logic [2:0] REFRESH_ZSV = 3'b100;
endpackage

// File: rtl/insn_wdog_cnt.sv
module insn_wdog_cnt
  import insn_wdog_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 65536,
  parameter int POR_CLKS     = 1024,
  parameter int OSC_EXTRA    = 18
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCtl_t ctl,
  output logic    atLimit,
  output logic    rstReq
);
  localparam int CNT_W   = (TIMEOUT_CLKS > 2) ? $clog2(TIMEOUT_CLKS) : 1;
  localparam int STRETCH = POR_CLKS + OSC_EXTRA;
  localparam int STR_W   = $clog2(STRETCH + 1);
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(TIMEOUT_CLKS - 1);
  localparam logic [STR_W-1:0] STR_VAL = STR_W'(STRETCH);

  logic [CNT_W-1:0] toCnt;
  logic [STR_W-1:0] strCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toCnt  <= '0;
      strCnt <= '0;
    end else begin
      if (ctl.clr)      toCnt <= '0;
      else if (ctl.run) toCnt <= toCnt + CNT_W'(1);

      if (ctl.fire)          strCnt <= STR_VAL;
      else if (strCnt != '0) strCnt <= strCnt - STR_W'(1);
    end
  end

  assign atLimit = (toCnt == LIMIT);
  assign rstReq  = (strCnt != '0);
endmodule

// File: rtl/insn_wdog_ctrl.sv
module insn_wdog_ctrl
  import insn_wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refreshStb,
  input  logic       haltRunStb,
  input  logic       inHalt,
  input  logic       inStop,
  input  logic       permOpt,
  input  logic       atLimit,
  input  logic       rstReq,
  output cntCtl_t    ctl,
  output logic       running,
  output logic       flagLoad,
  output logic [2:0] flagZsv
);
  logic swEn;      // set by the first refresh, sticky
  logic haltRun;   // keep counting in halt
  logic enEff;
  logic pwrOk;
  logic refreshOk;
  logic expire;

  assign enEff     = swEn | permOpt;
  // Stop outranks halt; the permanent option overrides both
  assign pwrOk     = permOpt | (!inStop && (!inHalt || haltRun));
  assign running   = enEff && pwrOk && !rstReq;
  assign refreshOk = refreshStb && !rstReq;
  assign expire    = running && atLimit && !refreshOk;

  always_comb begin
    ctl      = '0;
    ctl.run  = running;
    ctl.clr  = refreshOk | expire;
    ctl.fire = expire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swEn    <= 1'b0;
      haltRun <= 1'b0;
    end else if (expire && !permOpt) begin
      swEn    <= 1'b0;
      haltRun <= 1'b0;
    end else begin
      if (refreshOk)                        swEn    <= 1'b1;
      if (haltRunStb && swEn && !rstReq)    haltRun <= 1'b1;
    end
  end

  assign flagLoad = refreshStb;
  assign flagZsv  = REFRESH_ZSV;
endmodule

// File: rtl/insn_watchdog.sv
module insn_watchdog
  import insn_wdog_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 65536,
  parameter int POR_CLKS     = 1024,
  parameter int OSC_EXTRA    = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refreshStb,
  input  logic       haltRunStb,
  input  logic       inHalt,
  input  logic       inStop,
  input  logic       permOpt,
  output logic       wdReset,
  output logic       wdRunning,
  output logic       flagLoad,
  output logic [2:0] flagZsv
);
  cntCtl_t ctl;
  logic    atLimit;
  logic    rstReq;

  insn_wdog_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refreshStb (refreshStb),
    .haltRunStb (haltRunStb),
    .inHalt     (inHalt),
    .inStop     (inStop),
    .permOpt    (permOpt),
    .atLimit    (atLimit),
    .rstReq     (rstReq),
    .ctl        (ctl),
    .running    (wdRunning),
    .flagLoad   (flagLoad),
    .flagZsv    (flagZsv)
  );

  insn_wdog_cnt #(
    .TIMEOUT_CLKS (TIMEOUT_CLKS),
    .POR_CLKS     (POR_CLKS),
    .OSC_EXTRA    (OSC_EXTRA)
  ) u_cnt (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .atLimit (atLimit),
    .rstReq  (rstReq)
  );

  assign wdReset = rstReq;
endmodule

// File: rtl/insn_wdog_chk.sv
module insn_wdog_chk #(
  parameter int POR_CLKS  = 1024,
  parameter int OSC_EXTRA = 18
) (
  input logic clk,
  input logic rstN,
  input logic refreshStb,
  input logic inHalt,
  input logic inStop,
  input logic permOpt,
  input logic wdReset,
  input logic wdRunning
);
  localparam int STRETCH = POR_CLKS + OSC_EXTRA;

  int unsigned hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hiCnt <= 0;
    else if (wdReset) hiCnt <= hiCnt + 1;
    else              hiCnt <= 0;
  end

  p_quiet_in_stretch_r4: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> !wdRunning);

  p_stretch_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdReset) |-> (hiCnt == STRETCH));

  p_rise_after_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdReset) |-> ($past(wdRunning) && !$past(refreshStb)));

  p_stop_pause_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inStop && !permOpt) |-> !wdRunning);

  p_perm_runs_r10: assert property (@(posedge clk) disable iff (!rstN)
    (permOpt && !wdReset) |-> wdRunning);

  p_enable_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    wdRunning |=> (wdRunning || wdReset || inHalt || inStop));
endmodule

bind insn_watchdog insn_wdog_chk #(
  .POR_CLKS  (POR_CLKS),
  .OSC_EXTRA (OSC_EXTRA)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .refreshStb (refreshStb),
  .inHalt     (inHalt),
  .inStop     (inStop),
  .permOpt    (permOpt),
  .wdReset    (wdReset),
  .wdRunning  (wdRunning)
);

// File: tb/sim_insn_watchdog.sv
`timescale 1ns/1ps
module sim_insn_watchdog;
  localparam int T = 40;
  localparam int P = 12;
  localparam int X = 18;
  localparam int S = P + X;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refreshStb = 1'b0, haltRunStb = 1'b0;
  logic inHalt = 1'b0, inStop = 1'b0, permOpt = 1'b0;
  logic wdReset, wdRunning, flagLoad;
  logic [2:0] flagZsv;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  insn_watchdog #(.TIMEOUT_CLKS(T), .POR_CLKS(P), .OSC_EXTRA(X)) u0 (
    .clk(clk), .rstN(rstN), .refreshStb(refreshStb), .haltRunStb(haltRunStb),
    .inHalt(inHalt), .inStop(inStop), .permOpt(permOpt),
    .wdReset(wdReset), .wdRunning(wdRunning),
    .flagLoad(flagLoad), .flagZsv(flagZsv)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic perm);
    @(negedge clk);
    rstN = 1'b0; refreshStb = 0; haltRunStb = 0; inHalt = 0; inStop = 0;
    permOpt = perm;
    waitN(3);
    rstN = 1'b1;
  endtask

  task automatic pulseRefresh();
    refreshStb = 1'b1;
    @(negedge clk);
    refreshStb = 1'b0;
  endtask

  task automatic pulseHaltRun();
    haltRunStb = 1'b1;
    @(negedge clk);
    haltRunStb = 1'b0;
  endtask

  task automatic tReset();
    doReset(1'b0);
    check("R1 reset wdReset", {2'b0, wdReset}, 3'b000);
    check("R1 reset wdRunning", {2'b0, wdRunning}, 3'b000);
    waitN(5);
    check("R1 idle no strobe", {2'b0, wdRunning}, 3'b000);
  endtask

  task automatic tEnable();
    doReset(1'b0);
    refreshStb = 1'b1;
    #1;
    check("R12 flagLoad", {2'b0, flagLoad}, 3'b001);
    check("R12 flagZsv", flagZsv, 3'b100);
    @(negedge clk);
    refreshStb = 1'b0;
    #1;
    check("R12 flagLoad idle", {2'b0, flagLoad}, 3'b000);
    check("R2 running after enable", {2'b0, wdRunning}, 3'b001);
  endtask

  task automatic tTimeout();
    doReset(1'b0);
    pulseRefresh();
    waitN(T - 1);
    check("R3 before limit", {2'b0, wdReset}, 3'b000);
    waitN(1);
    check("R3 at limit", {2'b0, wdReset}, 3'b001);
    pulseRefresh();
    waitN(S - 2);
    check("R4 last stretch cycle", {2'b0, wdReset}, 3'b001);
    waitN(1);
    check("R4 stretch ended", {2'b0, wdReset}, 3'b000);
    check("R11 R4 latch cleared, refresh ignored", {2'b0, wdRunning}, 3'b000);
    waitN(T + 3);
    check("R11 no further reset", {2'b0, wdReset}, 3'b000);
  endtask

  task automatic tRefresh();
    doReset(1'b0);
    pulseRefresh();
    waitN(T - 1);
    pulseRefresh();
    check("R3 refresh in last cycle", {2'b0, wdReset}, 3'b000);
    waitN(T - 1);
    check("R3 after refresh before limit", {2'b0, wdReset}, 3'b000);
    waitN(1);
    check("R3 after refresh at limit", {2'b0, wdReset}, 3'b001);
  endtask

  task automatic tHaltPause();
    doReset(1'b0);
    pulseRefresh();
    waitN(10);
    inHalt = 1'b1;
    waitN(50);
    check("R6 paused in halt", {2'b0, wdRunning}, 3'b000);
    check("R6 no reset in halt", {2'b0, wdReset}, 3'b000);
    inHalt = 1'b0;
    #1;
    check("R5 resumes after halt", {2'b0, wdRunning}, 3'b001);
    waitN(T - 11);
    check("R5 count kept before limit", {2'b0, wdReset}, 3'b000);
    waitN(1);
    check("R5 count kept at limit", {2'b0, wdReset}, 3'b001);
  endtask

  task automatic tHaltRun();
    doReset(1'b0);
    pulseRefresh();
    waitN(5);
    pulseHaltRun();
    inHalt = 1'b1;
    waitN(T - 7);
    check("R7 counting in halt", {2'b0, wdRunning}, 3'b001);
    check("R7 count not cleared, before limit", {2'b0, wdReset}, 3'b000);
    waitN(1);
    check("R7 count not cleared, at limit", {2'b0, wdReset}, 3'b001);
  endtask

  task automatic tHaltRunEarly();
    doReset(1'b0);
    pulseHaltRun();
    pulseRefresh();
    inHalt = 1'b1;
    waitN(5);
    check("R8 early halt-run ignored", {2'b0, wdRunning}, 3'b000);
    waitN(T + 5);
    check("R8 no timeout in halt", {2'b0, wdReset}, 3'b000);
  endtask

  task automatic tStop();
    doReset(1'b0);
    pulseRefresh();
    pulseHaltRun();
    inStop = 1'b1;
    inHalt = 1'b1;
    waitN(T + 5);
    check("R9 stopped", {2'b0, wdRunning}, 3'b000);
    check("R9 no timeout in stop", {2'b0, wdReset}, 3'b000);
  endtask

  task automatic tPerm();
    doReset(1'b1);
    inHalt = 1'b1;
    inStop = 1'b1;
    #1;
    check("R10 runs from reset", {2'b0, wdRunning}, 3'b001);
    waitN(T - 1);
    check("R10 before limit", {2'b0, wdReset}, 3'b000);
    waitN(1);
    check("R10 timeout through stop", {2'b0, wdReset}, 3'b001);
    waitN(S - 1);
    check("R4 perm stretch last", {2'b0, wdReset}, 3'b001);
    waitN(1);
    check("R4 perm stretch end", {2'b0, wdReset}, 3'b000);
    check("R11 perm resumes", {2'b0, wdRunning}, 3'b001);
  endtask

  initial begin
    fork
      begin
        tReset();
        tEnable();
        tTimeout();
        tRefresh();
        tHaltPause();
        tHaltRun();
        tHaltRunEarly();
        tStop();
        tPerm();
        doReset(1'b0);
      end
      begin
        repeat (20000) @(posedge clk);
        nFail++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule